// File: doc/BRIEF.md
# LPC Firmware Memory Read Target

This block is the target side of a firmware memory read on a 4-bit multiplexed LPC-style bus. Every rising clock edge it samples the active-low frame strobe and one nibble from the shared lines. It follows a fixed 17-clock exchange:

- a start code, followed by a device-select nibble that must match its strap ID;
- a 28-bit address, sent most significant nibble first;
- a size nibble;
- a host-to-target turnaround;
- a ready sync, then one data byte sent low nibble first;
- a target-to-host turnaround.

The byte comes from an attached synchronous byte memory. The block sends that memory a one-clock read request with the full address as soon as the last address nibble arrives. It registers the returned byte before the ready sync, so the byte stays fixed for both data clocks. It never drives the lines directly. The surrounding pad logic uses its output-enable to drive the lines only during the clocks that belong to the target. A wrong start code, a wrong device select, a nonzero size, or the frame strobe returning low in mid-exchange all send it back to idle without driving.

Top module: `lpc_fwrd_target`

## Requirements
- R1: While reset is asserted and after its release with no traffic, `lad_oe` and `mem_req` are 0.
- R2: The start code is the last nibble sampled while `frame_n` is low. The exchange proceeds only if it equals 4'b1101. Earlier nibbles with `frame_n` low are ignored. Any other final start value gives no request and no driving.
- R3: The nibble sampled on the first clock with `frame_n` high (clock 2) must equal `strap_id`, otherwise the target returns to idle with no request and no driving.
- R4: Clocks 3 to 9 carry address bits [27:24] down to [3:0], in that order. `mem_req` is 1 for exactly clock 10, with `mem_addr` holding the full address. It is 0 at all other times.
- R5: The size nibble on clock 10 must be 4'b0000. Any other value gives no driving in clocks 11 to 17.
- R6: `lad_oe` is 0 in clock 11 (host turnaround). In clock 12 it is 1 with `lad_out` = 4'b1111. In clock 13 it is 1 with `lad_out` = 4'b0000 (ready sync).
- R7: In clock 14 `lad_out` = byte bits [3:0], and in clock 15 it is bits [7:4]. The byte is the memory's reply to the request of R4.
- R8: In clock 16 `lad_oe` is 1 with `lad_out` = 4'b1111. From clock 17 on `lad_oe` is 0, and a new exchange may start on the next clock.
- R9: If `frame_n` is sampled low during any clock from 3 to 16, the exchange is dropped. `lad_oe` is 0 from the following clock, and that nibble is treated as a new start candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the shared lines |
| strap_id | input | 4 | Device-select value this target answers to |
| lad_out | output | 4 | Nibble to drive when `lad_oe` is 1 |
| lad_oe | output | 1 | Output-enable for the shared lines |
| mem_req | output | 1 | One-clock read request to the byte memory |
| mem_addr | output | 28 | Read address, valid while `mem_req` is 1 |
| mem_rdata | input | 8 | Byte from the memory, valid the clock after `mem_req` |

## Verification
The assertions check the following on every cycle:

- the read request lasts one clock and never overlaps a driven clock;
- a low frame strobe always releases the lines on the next clock;
- every driven window opens with 1111 and is followed by the ready sync;
- every window that is not aborted closes on a 1111 nibble.

Other behaviour can only be shown by the bench's scenarios:

- whether a header is accepted or rejected for its start code, device select and size;
- the order of the address nibbles;
- the byte value returned in each data nibble;
- the exact clock on which a mid-exchange abort takes effect.

// File: rtl/lpc_fwrd_target.sv
module lpc_fwrd_target #(
  parameter int          ADDR_W     = 28,
  parameter logic [3:0]  START_CODE = 4'b1101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  input  logic [3:0]        strap_id,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  localparam int NIB = ADDR_W / 4;
  localparam int CW  = (NIB > 1) ? $clog2(NIB) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIB - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_ADDR, S_SIZE, S_TARH, S_TART, S_SYNC, S_DLO, S_DHI, S_TARE
  } st_t;

  st_t              state;
  logic [3:0]       start_q;
  logic [CW-1:0]    cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]       data_q;
  logic             req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      start_q <= '0;
      cnt     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!frame_n) begin
        state   <= S_HDR;
        start_q <= lad_in;
      end else begin
        case (state)
          S_HDR: begin
            cnt   <= '0;
            state <= (start_q == START_CODE && lad_in == strap_id) ? S_ADDR : S_IDLE;
          end
          S_ADDR: begin
            addr_q <= {addr_q[ADDR_W-5:0], lad_in};
            cnt    <= cnt + 1'b1;
            if (cnt == LAST) begin
              state <= S_SIZE;
              req_q <= 1'b1;
            end
          end
          S_SIZE:  state <= (lad_in == 4'b0000) ? S_TARH : S_IDLE;
          S_TARH: begin
            data_q <= mem_rdata;
            state  <= S_TART;
          end
          S_TART:  state <= S_SYNC;
          S_SYNC:  state <= S_DLO;
          S_DLO:   state <= S_DHI;
          S_DHI:   state <= S_TARE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign lad_oe   = state inside {S_TART, S_SYNC, S_DLO, S_DHI, S_TARE};

  always_comb begin
    case (state)
      S_TART, S_TARE: lad_out = 4'b1111;
      S_DLO:          lad_out = data_q[3:0];
      S_DHI:          lad_out = data_q[7:4];
      default:        lad_out = 4'b0000;
    endcase
  end
endmodule

// File: rtl/lpc_fwrd_chk.sv
module lpc_fwrd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       lad_oe,
  input logic [3:0] lad_out,
  input logic       mem_req
);
  AST_REQ_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R4
  AST_REQ_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !lad_oe); // R4
  AST_OPEN_HIGH:    assert property (@(posedge clk) disable iff (!rst_n) $rose(lad_oe) |-> lad_out == 4'b1111); // R6
  AST_SYNC_NEXT:    assert property (@(posedge clk) disable iff (!rst_n) $rose(lad_oe) |=> (!lad_oe || lad_out == 4'b0000)); // R6
  AST_CLOSE_HIGH:   assert property (@(posedge clk) disable iff (!rst_n) ($fell(lad_oe) && $past(frame_n)) |-> $past(lad_out) == 4'b1111); // R8
  AST_FRAME_DROPS:  assert property (@(posedge clk) disable iff (!rst_n) !frame_n |=> !lad_oe); // R9
endmodule

bind lpc_fwrd_target lpc_fwrd_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
  .lad_oe(lad_oe), .lad_out(lad_out), .mem_req(mem_req)
);

// File: tb/lpc_fwrd_target_tb_top.sv
module lpc_fwrd_target_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  strap_id = 4'h5;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        mem_req;
  logic [27:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lpc_fwrd_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .strap_id(strap_id), .lad_out(lad_out), .lad_oe(lad_oe),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_val(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ a[27:20] ^ {a[19:16], a[3:0]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= mem_val(mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_txn(input logic [3:0] stv, input logic [3:0] idv, input logic [27:0] a,
                         input logic [3:0] sz, input int pre, input int ab);
    logic [3:0] nib [40];
    logic       fr  [40];
    int n;
    bit hdr_ok, good;
    string tag;
    logic [7:0] d;
    n = pre + 17;
    for (int i = 0; i < 40; i++) begin nib[i] = 4'hF; fr[i] = 1'b1; end
    for (int i = 0; i < pre; i++) begin fr[i] = 1'b0; nib[i] = 4'($urandom()); end
    fr[pre] = 1'b0; nib[pre] = stv;
    nib[pre+1] = idv;
    for (int m = 0; m < 7; m++) nib[pre+2+m] = a[27-4*m -: 4];
    nib[pre+9] = sz;
    if (ab > 0) begin fr[pre+ab-1] = 1'b0; nib[pre+ab-1] = 4'h0; end
    hdr_ok = (stv == 4'b1101) && (idv == strap_id);
    good   = hdr_ok && (sz == 4'b0000);
    d      = mem_val(a);
    if (stv != 4'b1101)      tag = "R2";
    else if (idv != strap_id) tag = "R3";
    else if (ab > 0)          tag = "R9";
    else if (sz != 4'b0000)   tag = "R5";
    else                      tag = "R6";
    for (int k = 0; k < n + 2; k++) begin
      int j;
      bit eoe, ereq;
      logic [3:0] eout;
      string t;
      @(negedge clk);
      j    = k - pre + 1;
      eoe  = good && (j >= 12) && (j <= 16) && !(ab > 0 && j > ab);
      ereq = hdr_ok && (j == 10) && !(ab > 0 && ab <= 9);
      case (j)
        14: eout = d[3:0];
        15: eout = d[7:4];
        13: eout = 4'h0;
        default: eout = 4'hF;
      endcase
      if (j == 12 || j == 13)      t = (tag == "R6") ? "R6" : tag;
      else if (j == 14 || j == 15) t = (tag == "R6") ? "R7" : tag;
      else if (j == 16 || j == 17) t = (tag == "R6") ? "R8" : tag;
      else                         t = tag;
      chk(lad_oe == eoe, {t, " oe"}, 32'(lad_oe), 32'(eoe));
      if (eoe) chk(lad_out == eout, {t, " nibble"}, 32'(lad_out), 32'(eout));
      chk(mem_req == ereq, "R4 req", 32'(mem_req), 32'(ereq));
      if (ereq) chk(mem_addr == a, "R4 addr", 32'(mem_addr), 32'(a));
      if (k < n) begin frame_n = fr[k]; lad_in = nib[k]; end
      else begin frame_n = 1'b1; lad_in = 4'hF; end
    end
  endtask

  initial begin
    void'($urandom(32'd1307));
    repeat (3) begin
      @(negedge clk);
      chk(lad_oe == 1'b0 && mem_req == 1'b0, "R1 reset", {lad_oe, mem_req}, 0);
    end
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(lad_oe == 1'b0 && mem_req == 1'b0, "R1 idle", {lad_oe, mem_req}, 0);
    end
    run_txn(4'hD, 4'h5, 28'h123_4567, 4'h0, 0, 0);
    run_txn(4'hD, 4'h5, 28'hFFF_FFFF, 4'h0, 0, 0);
    run_txn(4'hD, 4'h5, 28'h000_0000, 4'h0, 0, 0);
    run_txn(4'hD, 4'h5, 28'hA5C_3E1F, 4'h0, 3, 0);
    run_txn(4'hB, 4'h5, 28'h0AB_CDEF, 4'h0, 2, 0);
    run_txn(4'hD, 4'h6, 28'h765_4321, 4'h0, 0, 0);
    run_txn(4'hD, 4'h5, 28'h111_2222, 4'h1, 0, 0);
    run_txn(4'hD, 4'h5, 28'h333_4444, 4'h0, 0, 5);
    run_txn(4'hD, 4'h5, 28'h555_6666, 4'h0, 0, 14);
    for (int r = 0; r < 80; r++) begin
      logic [3:0] st, id, sz;
      int pre, ab;
      strap_id = 4'($urandom());
      st  = ($urandom() % 5 == 0) ? 4'($urandom()) : 4'hD;
      id  = ($urandom() % 5 == 0) ? 4'($urandom()) : strap_id;
      sz  = ($urandom() % 6 == 0) ? 4'($urandom()) : 4'h0;
      pre = int'($urandom() % 3);
      ab  = ($urandom() % 8 == 0) ? int'(3 + $urandom() % 14) : 0;
      run_txn(st, id, 28'($urandom()), sz, pre, ab);
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule